// File: doc/BRIEF.md
# Register File with Same-Cycle Write Bypass

This block is the architectural register store of a small in-order pipelined core. It holds a bank of general-purpose registers and has two read ports and one write port. The read ports are combinational: an address selects a register and its contents appear on the data output in the same cycle. The write port is synchronous. The data, the destination index and the enable are sampled together at the rising clock edge, and that edge is the only moment the storage changes.

A build-time mode parameter decides what a read returns when it names the register that is being written in the same cycle. In `RF_READ_OLD` mode the read returns the value already stored, and the new value becomes readable one cycle later. In `RF_READ_NEW` mode the incoming write data is steered straight to the read output. This behaves as if the write happened in the first half of the cycle and the read in the second half, so a pipeline that writes back and decodes in the same cycle sees no hazard on that register. The highest-numbered register is a hardwired zero. It never holds a written value and is never bypassed.

Top module: `rf_wt_top`

## Requirements
- R1: A synchronous active-high reset clears every register, so each register reads zero once reset has been sampled at a rising edge.
- R2: When `wr_en` is high and `wr_addr` is not the zero register, `wr_data` is stored at the rising edge, and any later cycle reads it back on either port.
- R3: While `wr_en` is low, a rising edge leaves every register unchanged, whatever `wr_addr` and `wr_data` carry.
- R4: In `RF_READ_OLD` mode, a read of the register being written in the same cycle returns the previously stored value.
- R5: In `RF_READ_NEW` mode, a read of the register being written in the same cycle returns `wr_data` in that same cycle.
- R6: The bypass acts only when `wr_en` is high and the read address equals `wr_addr`. Otherwise a read returns the stored contents.
- R7: Register index 31 (`ZERO_REG`) always reads zero. Writes to it are dropped and it is never bypassed, in either mode.
- R8: The two read ports work independently. Each applies the bypass rule to its own address, and two ports given the same address return the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_addr | input | 5 | Destination register index |
| wr_data | input | 64 | Value to store |
| rd0_addr | input | 5 | Read port 0 register index |
| rd0_data | output | 64 | Read port 0 data, combinational |
| rd1_addr | input | 5 | Read port 1 register index |
| rd1_data | output | 64 | Read port 1 data, combinational |

## Verification
The same stimulus drives two instances side by side, one in each mode. A same-cycle write and read of one register therefore separates the stored value from the bypassed value, while reads of other registers must agree across the two instances. The patterns include these cases:
- a write with the enable low, which tells a gated write from a leaked one;
- a write aimed at the zero register, read back in the same cycle and the next, which catches a zero register that is stored or forwarded;
- both ports naming the register under write, which exposes a bypass wired to only one port.

A sweep of all indices after reset, and a second reset after data has been written, confirm that clearing reaches every entry.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Same-cycle read/write policy
  typedef enum logic {
    RF_READ_OLD = 1'b0,  // read sees value from earlier cycles
    RF_READ_NEW = 1'b1   // read sees data being written this cycle
  } rf_mode_e;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int NREGS    = 32,
  parameter int DW       = 64,
  parameter int AW       = 5,
  parameter int ZERO_IDX = 31
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [NREGS-1:0][DW-1:0]  regs_q,
  output logic                      wr_fire
);

  // A write takes effect only when enabled and not aimed at the zero register
  assign wr_fire = wr_en && (wr_addr != AW'(ZERO_IDX));

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == ZERO_IDX) begin : g_zero
      always_ff @(posedge clk) regs_q[g] <= '0;
    end else begin : g_data
      always_ff @(posedge clk) begin
        if (rst)
          regs_q[g] <= '0;
        else if (wr_fire && (wr_addr == AW'(g)))
          regs_q[g] <= wr_data;
      end
    end
  end

  // R1: reset clears everything at the next edge
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (regs_q == '0));

  // R2: a fired write is visible in storage after the edge
  assert_write_commits_R2: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

  // R3: no enable, no change
  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
#(
  parameter int       NREGS    = 32,
  parameter int       DW       = 64,
  parameter int       AW       = 5,
  parameter int       ZERO_IDX = 31,
  parameter rf_mode_e MODE     = RF_READ_NEW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREGS-1:0][DW-1:0]  regs_q,
  input  logic [AW-1:0]             rd_addr,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [DW-1:0]             rd_data,
  output logic                      byp_hit
);

  // Forwarding condition: enabled write to the same, non-zero register
  function automatic logic fwd_match(input logic en, input logic [AW-1:0] wa,
                                     input logic [AW-1:0] ra);
    return en && (wa == ra) && (ra != AW'(ZERO_IDX));
  endfunction

  logic [DW-1:0] stored_val;
  logic          is_zero;

  assign is_zero    = (rd_addr == AW'(ZERO_IDX));
  assign stored_val = is_zero ? '0 : regs_q[rd_addr];

  if (MODE == RF_READ_NEW) begin : g_fwd
    assign byp_hit = fwd_match(wr_en, wr_addr, rd_addr);

    // R5: same-cycle read of the written register returns the new data
    assert_new_value_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr == rd_addr) && (rd_addr != AW'(ZERO_IDX)))
        |-> (rd_data == wr_data));
  end else begin : g_nofwd
    assign byp_hit = 1'b0;

    // R4: the read always reflects storage in this mode
    assert_old_value_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_addr != AW'(ZERO_IDX)) |-> (rd_data == regs_q[rd_addr]));
  end

  assign rd_data = byp_hit ? wr_data : stored_val;

  // R7: the zero register reads zero even under a write to it
  assert_zero_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(ZERO_IDX)) |-> (rd_data == '0));

  // R6: without a matching enabled write the read is plain storage
  assert_no_stray_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && (wr_addr == rd_addr)) && (rd_addr != AW'(ZERO_IDX)))
      |-> (rd_data == regs_q[rd_addr]));

endmodule

// File: rtl/rf_wt_top.sv
module rf_wt_top
  import rf_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter int       DATA_W   = 64,
  parameter int       ZERO_REG = 31,
  parameter rf_mode_e MODE     = RF_READ_NEW,
  parameter int       ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);

  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic                            wr_fire;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;
  logic [NUM_RD-1:0]               byp_hit_v;

  assign rd_addr_v[0] = rd0_addr;
  assign rd_addr_v[1] = rd1_addr;
  assign rd0_data     = rd_data_v[0];
  assign rd1_data     = rd_data_v[1];

  rf_store #(
    .NREGS(NUM_REGS), .DW(DATA_W), .AW(ADDR_W), .ZERO_IDX(ZERO_REG)
  ) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_q(regs_q), .wr_fire(wr_fire)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    rf_rd_port #(
      .NREGS(NUM_REGS), .DW(DATA_W), .AW(ADDR_W),
      .ZERO_IDX(ZERO_REG), .MODE(MODE)
    ) port_i (
      .clk(clk), .rst(rst), .regs_q(regs_q), .rd_addr(rd_addr_v[p]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(rd_data_v[p]), .byp_hit(byp_hit_v[p])
    );
  end

  // R8: ports with equal addresses agree
  assert_ports_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (rd0_addr == rd1_addr) |-> (rd0_data == rd1_data));

  // R7: a forward never happens together with a dropped (zero-register) write
  assert_no_zero_forward_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_fire) |-> (byp_hit_v == '0));

endmodule

// File: tb/rf_wt_top_tb.sv
module rf_wt_top_tb_top;
  import rf_pkg::*;

  localparam time CLK_PERIOD = 4ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd0_addr = '0;
  logic [4:0]  rd1_addr = '0;
  logic [63:0] n0, n1, o0, o1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_wt_top #(.MODE(RF_READ_NEW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(n0), .rd1_addr(rd1_addr), .rd1_data(n1));

  rf_wt_top #(.MODE(RF_READ_OLD)) dut_old_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(o0), .rd1_addr(rd1_addr), .rd1_data(o1));

  localparam logic [63:0] VA = 64'hA5A5_0000_0000_0001;
  localparam logic [63:0] VB = 64'h0000_0000_0000_00B2;
  localparam logic [63:0] VC = 64'h0000_0000_0000_00C3;
  localparam logic [63:0] VD = 64'h0000_0000_0000_00D4;
  localparam logic [63:0] VE = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] VF = 64'h0F0F_0F0F_0F0F_0F0F;
  localparam logic [63:0] VG = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] VH = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [63:0] wd;
    logic [4:0]  ra0;
    logic [4:0]  ra1;
    logic [63:0] new0;   // expected, bypass mode
    logic [63:0] new1;
    logic [63:0] old0;   // expected, stored-value mode
    logic [63:0] old1;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  // One row per cycle; values checked just before the committing edge
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd3,  VA, 5'd3,  5'd4,  VA,  64'd0, 64'd0, 64'd0, 4'd5}, // R5/R4 first write
    '{1'b1, 5'd4,  VB, 5'd3,  5'd4,  VA,  VB,    VA,    64'd0, 4'd5}, // R5/R4 port1 hit
    '{1'b0, 5'd3,  VC, 5'd3,  5'd4,  VA,  VB,    VA,    VB,    4'd3}, // R3 no-enable
    '{1'b0, 5'd5,  VD, 5'd3,  5'd5,  VA,  64'd0, VA,    64'd0, 4'd6}, // R6 address match, enable low
    '{1'b1, 5'd31, VE, 5'd31, 5'd4,  64'd0, VB,  64'd0, VB,    4'd7}, // R7 write to zero reg
    '{1'b1, 5'd7,  VF, 5'd31, 5'd7,  64'd0, VF,  64'd0, 64'd0, 4'd7}, // R7 zero stays zero
    '{1'b1, 5'd3,  VG, 5'd3,  5'd3,  VG,  VG,    VA,    VA,    4'd8}, // R8 both ports hit
    '{1'b0, 5'd0,  VH, 5'd3,  5'd7,  VG,  VF,    VG,    VF,    4'd2}, // R2 committed values
    '{1'b1, 5'd0,  VH, 5'd0,  5'd4,  VH,  VB,    64'd0, VB,    4'd5}, // R5 register zero index
    '{1'b0, 5'd0,  VC, 5'd0,  5'd31, VH,  64'd0, VH,    64'd0, 4'd2}  // R2 readback
  };

  function automatic string req_name(input logic [3:0] code);
    case (code)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5/R4";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp,
                       input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [4:0] wa, input logic [63:0] wd,
                       input logic [4:0] ra0, input logic [4:0] ra1);
    wr_en = we; wr_addr = wa; wr_data = wd; rd0_addr = ra0; rd1_addr = ra1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset across two edges
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset, both modes
    for (int a = 0; a < 32; a++) begin
      drive(1'b0, 5'd0, '0, 5'(a), 5'(31 - a));
      #1;
      check(n0, 64'd0, "R1", "reset sweep bypass port0");
      check(o1, 64'd0, "R1", "reset sweep old port1");
      @(negedge clk);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ra0, VECS[i].ra1);
      #1;
      check(n0, VECS[i].new0, req_name(VECS[i].req), $sformatf("vec%0d new port0", i));
      check(n1, VECS[i].new1, req_name(VECS[i].req), $sformatf("vec%0d new port1", i));
      check(o0, VECS[i].old0, req_name(VECS[i].req), $sformatf("vec%0d old port0", i));
      check(o1, VECS[i].old1, req_name(VECS[i].req), $sformatf("vec%0d old port1", i));
      @(negedge clk);
    end

    // R3: disabled write to an untouched register leaves it zero
    drive(1'b0, 5'd9, VE, 5'd9, 5'd9);
    @(negedge clk);
    drive(1'b0, 5'd0, '0, 5'd9, 5'd9);
    #1;
    check(n0, 64'd0, "R3", "disabled write bypass mode");
    check(o0, 64'd0, "R3", "disabled write old mode");
    @(negedge clk);

    // R7: a same-cycle zero-register write is not forwarded to port1 either
    drive(1'b1, 5'd31, VG, 5'd4, 5'd31);
    #1;
    check(n1, 64'd0, "R7", "zero reg same cycle bypass mode");
    check(n0, VB, "R6", "other register unaffected");
    @(negedge clk);

    // R6: enabled write elsewhere does not disturb a read
    drive(1'b1, 5'd10, VD, 5'd3, 5'd10);
    #1;
    check(n0, VG, "R6", "non-matching address bypass mode");
    check(n1, VD, "R5", "matching address bypass mode");
    check(o1, 64'd0, "R4", "matching address old mode");
    @(negedge clk);

    // R1: a second reset clears written registers
    rst = 1'b1;
    drive(1'b0, 5'd0, '0, 5'd3, 5'd7);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(n0, 64'd0, "R1", "reg3 after second reset");
    check(o1, 64'd0, "R1", "reg7 after second reset");
    @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule